// File: doc/BRIEF.md
# Real-Mode Linear Address Generator

This block turns a 16-bit segment selector and a 16-bit effective address into a linear address, the way a processor core running legacy 16-bit code forms memory references. The effective address is built from an optional base register (BX or BP), an optional index register (SI or DI) and a displacement. The displacement may be absent, an 8-bit value that is sign-extended, or a full 16-bit value. The sum wraps at 64 KiB. The segment base is the selector shifted left by four bit positions, and it is added to the offset with no wrap at 1 MiB. This means selectors near FFFFh reach the band just above 1 MiB, up to 10FFEFh.

No descriptor lookup is made. Every segment behaves as a writable code segment whose limit is a fixed 64 KiB. Alongside the address, the block raises a limit-fault flag when the bytes touched by an access of the requested size would run past the segment limit. The address is still produced when the flag is raised, so the issuing pipeline can decide what to do with it. Inputs are captured on a valid strobe, and results appear one clock later. The outputs hold their values while no new request is presented.

Top module: `rm_agu`

## Requirements
- R1: While rst_n is low, out_valid, lim_fault and lin_addr are all zero.
- R2: out_valid is high in the cycle after a clock edge that sampled in_valid high, and low otherwise. When in_valid was low at an edge, lin_addr and lim_fault keep their previous values.
- R3: base_sel picks the base term: 2'b00 none (zero), 2'b01 reg_bx, 2'b10 reg_bp, 2'b11 none (zero).
- R4: idx_sel picks the index term: 2'b00 none (zero), 2'b01 reg_si, 2'b10 reg_di, 2'b11 none (zero).
- R5: disp_mode picks the displacement term: 2'b00 zero, 2'b01 disp[7:0] sign-extended to 16 bits, 2'b10 disp[15:0], 2'b11 zero.
- R6: The offset is (base + index + displacement) modulo 2^16.
- R7: lin_addr equals seg_sel * 16 + offset, computed without truncation to 20 bits. lin_addr[31:21] are always zero.
- R8: acc_size gives the access width: 2'b00 one byte, 2'b01 two bytes, 2'b10 and 2'b11 four bytes. lim_fault is 1 exactly when offset + width - 1 exceeds FFFFh. lin_addr is produced regardless of the fault.
- R9: The highest reachable address is 10FFEFh (selector FFFFh, offset FFFFh), and lin_addr never exceeds it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; captures the inputs at the clock edge |
| seg_sel | input | 16 | Segment selector |
| reg_bx | input | 16 | BX register value |
| reg_bp | input | 16 | BP register value |
| reg_si | input | 16 | SI register value |
| reg_di | input | 16 | DI register value |
| disp | input | 16 | Displacement field |
| base_sel | input | 2 | Base register choice (R3) |
| idx_sel | input | 2 | Index register choice (R4) |
| disp_mode | input | 2 | Displacement form (R5) |
| acc_size | input | 2 | Access width code (R8) |
| out_valid | output | 1 | Result valid |
| lin_addr | output | 32 | Zero-extended linear address |
| lim_fault | output | 1 | Access crosses the segment limit |

## Verification
The assertions check properties that hold on every cycle. The valid bit tracks the strobe one cycle late, results hold while idle, and the address always lies within 64 KiB above the base of the captured selector. The address never passes 10FFEFh, and a one-byte access never faults. Only the bench's sweeps show the exact offset arithmetic for every selector encoding. These sweeps cover the wrap of the offset sum at 64 KiB, the sign extension of short displacements, and the exact fault boundary for two- and four-byte accesses near FFFFh. For each case the bench computes the expected values itself.

// File: rtl/rm_agu_pkg.sv
package rm_agu_pkg;

  typedef enum logic [1:0] {
    BASE_NONE = 2'b00,
    BASE_BX   = 2'b01,
    BASE_BP   = 2'b10,
    BASE_RSVD = 2'b11
  } base_sel_e;

  typedef enum logic [1:0] {
    IDX_NONE = 2'b00,
    IDX_SI   = 2'b01,
    IDX_DI   = 2'b10,
    IDX_RSVD = 2'b11
  } idx_sel_e;

  typedef enum logic [1:0] {
    DISP_ZERO  = 2'b00,
    DISP_SHORT = 2'b01,
    DISP_FULL  = 2'b10,
    DISP_RSVD  = 2'b11
  } disp_mode_e;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'b00,
    ACC_WORD  = 2'b01,
    ACC_DWORD = 2'b10,
    ACC_WIDE  = 2'b11
  } acc_size_e;

  localparam int unsigned SHORT_DISP_W = 8;

  // Number of extra bytes beyond the first for each access width code
  function automatic logic [2:0] acc_extra(input acc_size_e sz);
    case (sz)
      ACC_BYTE: acc_extra = 3'd0;
      ACC_WORD: acc_extra = 3'd1;
      default:  acc_extra = 3'd3;
    endcase
  endfunction

endpackage

// File: rtl/rm_agu_ea.sv
module rm_agu_ea
  import rm_agu_pkg::*;
#(
  parameter int unsigned OFS_W = 16
) (
  input  base_sel_e          base_sel,
  input  idx_sel_e           idx_sel,
  input  disp_mode_e         disp_mode,
  input  logic [OFS_W-1:0]   reg_bx,
  input  logic [OFS_W-1:0]   reg_bp,
  input  logic [OFS_W-1:0]   reg_si,
  input  logic [OFS_W-1:0]   reg_di,
  input  logic [OFS_W-1:0]   disp,
  output logic [OFS_W-1:0]   offset
);

  localparam int unsigned EXT_W = OFS_W - SHORT_DISP_W;

  logic [OFS_W-1:0] base_term;
  logic [OFS_W-1:0] idx_term;
  logic [OFS_W-1:0] disp_term;
  logic [OFS_W-1:0] short_ext;

  assign short_ext = {{EXT_W{disp[SHORT_DISP_W-1]}}, disp[SHORT_DISP_W-1:0]};

  always_comb begin
    case (base_sel)
      BASE_BX: base_term = reg_bx;
      BASE_BP: base_term = reg_bp;
      default: base_term = '0;
    endcase
  end

  always_comb begin
    case (idx_sel)
      IDX_SI:  idx_term = reg_si;
      IDX_DI:  idx_term = reg_di;
      default: idx_term = '0;
    endcase
  end

  always_comb begin
    case (disp_mode)
      DISP_SHORT: disp_term = short_ext;
      DISP_FULL:  disp_term = disp;
      default:    disp_term = '0;
    endcase
  end

  // Sum truncated to OFS_W bits: wraps at the segment size
  assign offset = base_term + idx_term + disp_term;

endmodule

// File: rtl/rm_agu_limit.sv
module rm_agu_limit
  import rm_agu_pkg::*;
#(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned SEG_LIMIT = 65535
) (
  input  logic [OFS_W-1:0] offset,
  input  acc_size_e        acc_size,
  output logic             fault
);

  localparam int unsigned END_W = OFS_W + 1;
  localparam logic [END_W-1:0] LIMIT_V = END_W'(SEG_LIMIT);

  logic [END_W-1:0] last_byte;

  assign last_byte = {1'b0, offset} + END_W'(acc_extra(acc_size));
  assign fault     = (last_byte > LIMIT_V);

endmodule

// File: rtl/rm_agu_linear.sv
module rm_agu_linear #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFS_W = 16,
  parameter int unsigned SHIFT = 4,
  parameter int unsigned LIN_W = SEG_W + SHIFT + 1
) (
  input  logic [SEG_W-1:0] seg_sel,
  input  logic [OFS_W-1:0] offset,
  output logic [LIN_W-1:0] lin
);

  logic [LIN_W-1:0] seg_base;

  assign seg_base = LIN_W'({seg_sel, {SHIFT{1'b0}}});
  assign lin      = seg_base + LIN_W'(offset);

endmodule

// File: rtl/rm_agu.sv
module rm_agu
  import rm_agu_pkg::*;
#(
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned SHIFT     = 4,
  parameter int unsigned OUT_W     = 32,
  parameter int unsigned SEG_LIMIT = 65535,
  parameter bit          REG_OUT   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [15:0]      seg_sel,
  input  logic [15:0]      reg_bx,
  input  logic [15:0]      reg_bp,
  input  logic [15:0]      reg_si,
  input  logic [15:0]      reg_di,
  input  logic [15:0]      disp,
  input  logic [1:0]       base_sel,
  input  logic [1:0]       idx_sel,
  input  logic [1:0]       disp_mode,
  input  logic [1:0]       acc_size,
  output logic             out_valid,
  output logic [31:0]      lin_addr,
  output logic             lim_fault
);

  localparam int unsigned LIN_W = SEG_W + SHIFT + 1;

  logic [OFS_W-1:0] ea_ofs;
  logic [LIN_W-1:0] lin_c;
  logic             fault_c;

  rm_agu_ea #(.OFS_W(OFS_W)) u_ea (
    .base_sel  (base_sel_e'(base_sel)),
    .idx_sel   (idx_sel_e'(idx_sel)),
    .disp_mode (disp_mode_e'(disp_mode)),
    .reg_bx    (reg_bx[OFS_W-1:0]),
    .reg_bp    (reg_bp[OFS_W-1:0]),
    .reg_si    (reg_si[OFS_W-1:0]),
    .reg_di    (reg_di[OFS_W-1:0]),
    .disp      (disp[OFS_W-1:0]),
    .offset    (ea_ofs)
  );

  rm_agu_linear #(
    .SEG_W (SEG_W),
    .OFS_W (OFS_W),
    .SHIFT (SHIFT),
    .LIN_W (LIN_W)
  ) u_lin (
    .seg_sel (seg_sel[SEG_W-1:0]),
    .offset  (ea_ofs),
    .lin     (lin_c)
  );

  rm_agu_limit #(
    .OFS_W     (OFS_W),
    .SEG_LIMIT (SEG_LIMIT)
  ) u_lim (
    .offset   (ea_ofs),
    .acc_size (acc_size_e'(acc_size)),
    .fault    (fault_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic             vld_q,   vld_d;
      logic [LIN_W-1:0] lin_q,   lin_d;
      logic             fault_q, fault_d;

      // next-state: load on strobe, hold otherwise
      always_comb begin
        vld_d   = in_valid;
        lin_d   = lin_q;
        fault_d = fault_q;
        if (in_valid) begin
          lin_d   = lin_c;
          fault_d = fault_c;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q   <= 1'b0;
          lin_q   <= '0;
          fault_q <= 1'b0;
        end else begin
          vld_q   <= vld_d;
          lin_q   <= lin_d;
          fault_q <= fault_d;
        end
      end

      assign out_valid = vld_q;
      assign lin_addr  = OUT_W'(lin_q);
      assign lim_fault = fault_q;
    end else begin : g_comb
      assign out_valid = in_valid & rst_n;
      assign lin_addr  = rst_n ? OUT_W'(lin_c) : '0;
      assign lim_fault = fault_c & rst_n;
    end
  endgenerate

endmodule

// File: rtl/rm_agu_chk.sv
module rm_agu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] seg_sel,
  input logic [1:0]  base_sel,
  input logic [1:0]  idx_sel,
  input logic [1:0]  disp_mode,
  input logic [1:0]  acc_size,
  input logic        out_valid,
  input logic [31:0] lin_addr,
  input logic        lim_fault
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!out_valid && !lim_fault && lin_addr == 32'h0)
        else $error("reset state violated");
    end
  end

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(lin_addr) && $stable(lim_fault)));

  assert_bare_segment_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && base_sel == 2'b00 && idx_sel == 2'b00 && disp_mode == 2'b00)
      |=> (lin_addr == {12'h0, $past(seg_sel), 4'h0}));

  assert_seg_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((lin_addr - {12'h0, $past(seg_sel), 4'h0}) < 32'h0001_0000));

  assert_byte_no_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_size == 2'b00) |=> !lim_fault);

  assert_ceiling_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lin_addr <= 32'h0010_FFEF));

endmodule

bind rm_agu rm_agu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .seg_sel   (seg_sel),
  .base_sel  (base_sel),
  .idx_sel   (idx_sel),
  .disp_mode (disp_mode),
  .acc_size  (acc_size),
  .out_valid (out_valid),
  .lin_addr  (lin_addr),
  .lim_fault (lim_fault)
);

// File: tb/tb_rm_agu.sv
module tb_rm_agu;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] seg_sel, reg_bx, reg_bp, reg_si, reg_di, disp;
  logic [1:0]  base_sel, idx_sel, disp_mode, acc_size;
  logic        out_valid;
  logic [31:0] lin_addr;
  logic        lim_fault;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rm_agu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .seg_sel(seg_sel),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .disp(disp), .base_sel(base_sel), .idx_sel(idx_sel),
    .disp_mode(disp_mode), .acc_size(acc_size), .out_valid(out_valid),
    .lin_addr(lin_addr), .lim_fault(lim_fault)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_offset(input logic [1:0] bs, input logic [1:0] is,
                                    input logic [1:0] dm, input logic [15:0] bx,
                                    input logic [15:0] bp, input logic [15:0] si,
                                    input logic [15:0] di, input logic [15:0] d);
    int b, x, s;
    b = (bs == 2'd1) ? int'(bx) : (bs == 2'd2) ? int'(bp) : 0;       // R3
    x = (is == 2'd1) ? int'(si) : (is == 2'd2) ? int'(di) : 0;       // R4
    if (dm == 2'd1)      s = (d[7:0] >= 8'd128) ? int'(d[7:0]) - 256 : int'(d[7:0]); // R5
    else if (dm == 2'd2) s = int'(d);
    else                 s = 0;
    return (b + x + s) & 32'hFFFF;                                   // R6
  endfunction

  function automatic int span(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  // drive at negedge, let one edge capture, sample at the following negedge
  task automatic apply_and_check(input string tag);
    int ofs, exp_lin, exp_f;
    ofs     = exp_offset(base_sel, idx_sel, disp_mode, reg_bx, reg_bp, reg_si, reg_di, disp);
    exp_lin = int'(seg_sel) * 16 + ofs;                              // R7
    exp_f   = (ofs + span(acc_size) - 1 > 32'hFFFF) ? 1 : 0;         // R8
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check({tag, " R2 valid"}, out_valid, 1);
    check({tag, " R3/R4/R5/R6/R7 addr"}, lin_addr, exp_lin);
    check({tag, " R8 fault"}, lim_fault, exp_f);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    seg_sel = 16'h1234; reg_bx = 16'h1111; reg_bp = 16'h2222;
    reg_si = 16'h3333; reg_di = 16'h4444; disp = 16'h0055;
    base_sel = 2'd1; idx_sel = 2'd1; disp_mode = 2'd2; acc_size = 2'd0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset even with a request presented
    in_valid = 1'b1;
    @(negedge clk);
    check("R1 valid", out_valid, 0);
    check("R1 addr", lin_addr, 0);
    check("R1 fault", lim_fault, 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep every select and size code over several register patterns
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 256; c++) begin
        seg_sel = 16'(p * 16'h2493 + c * 7);
        reg_bx  = 16'(16'h8001 * p + c);
        reg_bp  = 16'(16'hF00F + p * 16'h1111);
        reg_si  = 16'(16'h7FFF + p * 16'h3001);
        reg_di  = 16'(16'hFFF0 - p * 16'h0101);
        disp    = 16'(16'h0080 + p * 16'h2C41 + c);
        base_sel  = c[7:6];
        idx_sel   = c[5:4];
        disp_mode = c[3:2];
        acc_size  = c[1:0];
        apply_and_check("sweep");
      end
    end

    // R9 and HMA reach: selector sweep with maximum offset
    for (int s = 0; s < 4096; s++) begin
      seg_sel = 16'(s * 16 + 15);
      base_sel = 2'd0; idx_sel = 2'd0; disp_mode = 2'd2; disp = 16'hFFFF;
      acc_size = 2'(s);
      apply_and_check("R9 sel");
    end
    check("R9 top", lin_addr, 32'h0010_FFEF);

    // R8 boundary near the limit with word and dword accesses
    for (int k = 0; k < 8; k++) begin
      for (int z = 0; z < 4; z++) begin
        seg_sel = 16'h0100; base_sel = 2'd1; idx_sel = 2'd0; disp_mode = 2'd0;
        reg_bx = 16'(16'hFFF8 + k); acc_size = 2'(z);
        apply_and_check("R8 edge");
      end
    end

    // R6 wrap: BP + DI + negative short disp crossing zero
    seg_sel = 16'h0000; base_sel = 2'd2; idx_sel = 2'd2; disp_mode = 2'd1;
    reg_bp = 16'h0001; reg_di = 16'h0000; disp = 16'h00FE; acc_size = 2'd0;
    apply_and_check("R6 wrap");
    check("R6 wrapped value", lin_addr, 32'h0000_FFFF);

    // R2: idle strobe holds outputs, valid drops
    in_valid = 1'b0;
    seg_sel = 16'hABCD; base_sel = 2'd1; reg_bx = 16'h0F0F; acc_size = 2'd2;
    @(posedge clk);
    @(negedge clk);
    check("R2 idle valid", out_valid, 0);
    check("R2 hold addr", lin_addr, 32'h0000_FFFF);
    check("R2 hold fault", lim_fault, 0);
    done = 1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < WATCHDOG) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", n);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule